// File: doc/BRIEF.md
# Trapping-Set Neutralization Message Network

This block is the control side-network that an iterative parity-check decoder uses to escape a stuck error pattern. It mirrors a small fixed bipartite graph of variable nodes and check nodes. Each check node stores, for every one of its links, a seed bit and a steering mask. Each variable node stores one relay bit. Once the decoder sees a trap, it pulses `start` with the current set of failing parity checks. The network then sends one-bit tokens across the graph, one hop per clock, for a fixed number of cycles. Every variable node that a token reaches raises its neutralize flag. The decoder datapath uses that flag to force the node's channel value and all of its outgoing messages to zero.

The graph is fixed at elaboration. Link `q` of check `j` attaches to variable `(j*LINK_STEP + q) mod NUM_VAR`. The configuration is loaded through a single-cycle write port before a run. Tokens that reach the same node in the same cycle are merged by OR, so the block needs no arbitration. Tokens still in flight when the cycle budget runs out are dropped.

Top module: `tnm_neut_net`

## Requirements
- R1: After reset, `busy`, `done` and every `neut` bit are 0, and all stored configuration is 0. A run started with every check failing then neutralizes no variable.
- R2: In the clock edge that samples `start`, check `j` seeds a token on link `q` only if `chk_unsat[j]` is 1 and its seed bit for edge `j*DEG_C+q` is 1. The target variable's `neut` bit is visible after the next edge.
- R3: A variable with its relay bit set that receives a token on some link sends a token, one edge later, on each of its other links. It never sends one back on the link it was reached through. With the relay bit clear, it sends nothing.
- R4: A check that receives a token on link `p` sends it out, one edge later, on each link `q` whose steering mask has bit `p` set. Bit 0 of a mask is link 0.
- R5: Tokens move one hop per clock. A run takes exactly `NT_CYCLES` edges after the start edge, with `busy` high between those edges. `done` is high for exactly one cycle after the last of them, and any token still in flight at that point is discarded.
- R6: `neut` bits set during a run stay set until the next `start`. The edge that samples `start` clears them all.
- R7: Tokens that reach one variable from several checks in the same cycle raise its flag once and need no arbitration.
- R8: A write with `cfg_we` set and kind 0 stores `cfg_data[0]` as the relay bit of variable `cfg_idx`. Kind 1 stores `cfg_data[0]` as the seed bit of edge `cfg_idx`. Kind 2 stores `cfg_data` as the steering mask of edge `cfg_idx`. An index beyond the variable count (kind 0) or beyond the edge count (kinds 1 and 2) changes nothing.
- R9: Edge `j*DEG_C+q` joins check `j` to variable `(j*LINK_STEP+q) mod NUM_VAR`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 relay bit, 1 seed bit, 2 steering mask |
| cfg_idx | input | IDX_W | Variable index (kind 0) or edge index (kinds 1, 2) |
| cfg_data | input | DEG_C | Write data; bit 0 for single-bit kinds |
| start | input | 1 | One-cycle pulse that begins a run |
| chk_unsat | input | NUM_CHK | Failing parity checks, sampled with `start` |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| neut | output | NUM_VAR | Per-variable neutralize flags |

## Verification
The assertions assume that `start` is a single-cycle pulse and that it does not arrive during the two cycles in which the internal reset is released. They also assume that configuration writes do not overlap a run. The bench waits several cycles after each reset and pulses `start` only while `busy` is low. It issues all writes before it starts a run. Sampled `chk_unsat` values are held stable around the start edge, so the expected seed set always comes from one well-defined vector.

// File: rtl/tnm_pkg.sv
`timescale 1ns/1ps
package tnm_pkg;

  typedef enum logic [1:0] {
    CK_VAR_FWD = 2'd0,
    CK_SEED    = 2'd1,
    CK_MASK    = 2'd2
  } cfg_kind_e;

  // Variable reached by link lnk of check chk in the fixed graph.
  function automatic int link_var(int chk, int lnk, int step, int nvar);
    return (chk * step + lnk) % nvar;
  endfunction

endpackage

// File: rtl/tnm_cfg_store.sv
`timescale 1ns/1ps
module tnm_cfg_store #(
  parameter int NV    = 8,
  parameter int NC    = 4,
  parameter int DC    = 4,
  parameter int IDX_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_i,
  input  logic                      we,
  input  logic [1:0]                kind,
  input  logic [IDX_W-1:0]          idx,
  input  logic [DC-1:0]             data,
  output logic [NV-1:0]             relay_o,
  output logic [NC*DC-1:0]          seed_o,
  output logic [NC*DC-1:0][DC-1:0]  mask_o
);
  localparam int NE = NC * DC;

  logic [NV-1:0]            relay_q, relay_n;
  logic [NE-1:0]            seed_q,  seed_n;
  logic [NE-1:0][DC-1:0]    mask_q,  mask_n;

  always_comb begin
    relay_n = relay_q;
    seed_n  = seed_q;
    mask_n  = mask_q;
    if (we) begin
      case (tnm_pkg::cfg_kind_e'(kind))
        tnm_pkg::CK_VAR_FWD: begin
          for (int v = 0; v < NV; v++)
            if (int'(idx) == v) relay_n[v] = data[0];
        end
        tnm_pkg::CK_SEED: begin
          for (int e = 0; e < NE; e++)
            if (int'(idx) == e) seed_n[e] = data[0];
        end
        tnm_pkg::CK_MASK: begin
          for (int e = 0; e < NE; e++)
            if (int'(idx) == e) mask_n[e] = data;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      relay_q <= '0;
      seed_q  <= '0;
      mask_q  <= '0;
    end else if (we) begin
      relay_q <= relay_n;
      seed_q  <= seed_n;
      mask_q  <= mask_n;
    end
  end

  assign relay_o = relay_q;
  assign seed_o  = seed_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/tnm_var_unit.sv
`timescale 1ns/1ps
module tnm_var_unit #(
  parameter int NV   = 8,
  parameter int NC   = 4,
  parameter int DC   = 4,
  parameter int STEP = 2,
  parameter int VIDX = 0
) (
  input  logic [NC*DC-1:0] c2v_i,
  input  logic             relay_i,
  output logic             hit_o,
  output logic [NC*DC-1:0] v2c_o
);
  localparam int NE = NC * DC;

  // Edge membership of this variable, fixed at elaboration.
  logic [NE-1:0] mine;
  always_comb begin
    for (int e = 0; e < NE; e++)
      mine[e] = (tnm_pkg::link_var(e / DC, e % DC, STEP, NV) == VIDX);
  end

  always_comb begin
    hit_o = |(c2v_i & mine);
    v2c_o = '0;
    for (int e = 0; e < NE; e++) begin
      if (mine[e]) begin
        for (int f = 0; f < NE; f++)
          if (f != e && mine[f] && c2v_i[f]) v2c_o[e] = relay_i;
      end
    end
  end
endmodule

// File: rtl/tnm_chk_unit.sv
`timescale 1ns/1ps
module tnm_chk_unit #(
  parameter int DC = 4
) (
  input  logic                   launch_i,
  input  logic                   unsat_i,
  input  logic [DC-1:0]          seed_i,
  input  logic [DC-1:0][DC-1:0]  mask_i,
  input  logic [DC-1:0]          v2c_i,
  output logic [DC-1:0]          seed_o,
  output logic [DC-1:0]          fwd_o
);
  always_comb begin
    for (int q = 0; q < DC; q++) begin
      seed_o[q] = launch_i & unsat_i & seed_i[q];
      fwd_o[q]  = |(mask_i[q] & v2c_i);
    end
  end
endmodule

// File: rtl/tnm_neut_net.sv
`timescale 1ns/1ps
module tnm_neut_net #(
  parameter int NUM_VAR   = 8,
  parameter int NUM_CHK   = 4,
  parameter int DEG_C     = 4,
  parameter int LINK_STEP = 2,
  parameter int NT_CYCLES = 5,
  parameter int IDX_W     = $clog2((NUM_CHK*DEG_C > NUM_VAR) ? NUM_CHK*DEG_C : NUM_VAR)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_kind,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic [DEG_C-1:0]     cfg_data,
  input  logic                 start,
  input  logic [NUM_CHK-1:0]   chk_unsat,
  output logic                 busy,
  output logic                 done,
  output logic [NUM_VAR-1:0]   neut
);
  localparam int NE    = NUM_CHK * DEG_C;
  localparam int CNT_W = (NT_CYCLES > 1) ? $clog2(NT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NT_CYCLES - 1);

  // Reset: asserted at once, released after two clocks.
  logic [1:0] rst_sync;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  logic [NUM_VAR-1:0]         relay;
  logic [NE-1:0]              seed_cfg;
  logic [NE-1:0][DEG_C-1:0]   mask_cfg;

  tnm_cfg_store #(
    .NV(NUM_VAR), .NC(NUM_CHK), .DC(DEG_C), .IDX_W(IDX_W)
  ) u_cfg (
    .clk(clk), .rst_i(rst_i), .we(cfg_we), .kind(cfg_kind),
    .idx(cfg_idx), .data(cfg_data),
    .relay_o(relay), .seed_o(seed_cfg), .mask_o(mask_cfg)
  );

  // Token registers, one per edge and direction.
  logic [NE-1:0]        c2v_q, c2v_n;
  logic [NE-1:0]        v2c_q, v2c_n;
  logic [NUM_VAR-1:0]   neut_q, neut_n;
  logic [CNT_W-1:0]     cnt_q, cnt_n;
  logic                 busy_q, busy_n;
  logic                 done_q, done_n;

  logic [NUM_VAR-1:0]          hit;
  logic [NUM_VAR-1:0][NE-1:0]  v2c_part;
  logic [NE-1:0]               seed_all;
  logic [NE-1:0]               fwd_all;

  for (genvar v = 0; v < NUM_VAR; v++) begin : g_var
    tnm_var_unit #(
      .NV(NUM_VAR), .NC(NUM_CHK), .DC(DEG_C), .STEP(LINK_STEP), .VIDX(v)
    ) u_var (
      .c2v_i(c2v_q), .relay_i(relay[v]),
      .hit_o(hit[v]), .v2c_o(v2c_part[v])
    );
  end

  for (genvar j = 0; j < NUM_CHK; j++) begin : g_chk
    tnm_chk_unit #(.DC(DEG_C)) u_chk (
      .launch_i(start),
      .unsat_i(chk_unsat[j]),
      .seed_i(seed_cfg[j*DEG_C +: DEG_C]),
      .mask_i(mask_cfg[j*DEG_C +: DEG_C]),
      .v2c_i(v2c_q[j*DEG_C +: DEG_C]),
      .seed_o(seed_all[j*DEG_C +: DEG_C]),
      .fwd_o(fwd_all[j*DEG_C +: DEG_C])
    );
  end

  logic [NE-1:0] v2c_merged;
  always_comb begin
    v2c_merged = '0;
    for (int v = 0; v < NUM_VAR; v++) v2c_merged = v2c_merged | v2c_part[v];
  end

  always_comb begin
    c2v_n  = c2v_q;
    v2c_n  = v2c_q;
    neut_n = neut_q;
    cnt_n  = cnt_q;
    busy_n = busy_q;
    done_n = 1'b0;
    if (start) begin
      c2v_n  = seed_all;
      v2c_n  = '0;
      neut_n = '0;
      cnt_n  = '0;
      busy_n = 1'b1;
    end else if (busy_q) begin
      neut_n = neut_q | hit;
      c2v_n  = fwd_all;
      v2c_n  = v2c_merged;
      if (cnt_q == LAST) begin
        busy_n = 1'b0;
        done_n = 1'b1;
        c2v_n  = '0;
        v2c_n  = '0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  logic step_en;
  assign step_en = start | busy_q;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      c2v_q  <= '0;
      v2c_q  <= '0;
      neut_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (step_en) begin
      c2v_q  <= c2v_n;
      v2c_q  <= v2c_n;
      neut_q <= neut_n;
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) done_q <= 1'b0;
    else        done_q <= done_n;
  end

  assign busy = busy_q;
  assign done = done_q;
  assign neut = neut_q;
endmodule

// File: rtl/tnm_neut_net_chk.sv
`timescale 1ns/1ps
module tnm_neut_net_chk #(
  parameter int NV = 8
) (
  input logic          clk,
  input logic          rst_ok,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [NV-1:0] neut
);
  // R5: the end-of-run marker lasts a single cycle.
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    done |=> !done);

  // R5: when the marker is up the run is over.
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    done |-> !busy);

  // R2: a start always begins a run.
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    start |=> busy);

  // R6: a start wipes every flag.
  p_start_clear_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    start |=> (neut == '0));

  // R6: without a start no flag ever drops.
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    !start |=> ((neut & $past(neut)) == $past(neut)));

  // R5: flags are frozen outside a run.
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (!busy && !start) |=> $stable(neut));
endmodule

bind tnm_neut_net tnm_neut_net_chk #(.NV(NUM_VAR)) u_chk (
  .clk(clk), .rst_ok(rst_i), .start(start),
  .busy(busy), .done(done), .neut(neut)
);

// File: tb/sim_tnm_neut_net.sv
`timescale 1ns/1ps
module sim_tnm_neut_net;
  localparam int NT = 5;

  logic       clk;
  logic       rst_n;
  logic       cfg_we;
  logic [1:0] cfg_kind;
  logic [3:0] cfg_idx;
  logic [3:0] cfg_data;
  logic       start;
  logic [3:0] chk_unsat;
  logic       busy;
  logic       done;
  logic [7:0] neut;

  tnm_neut_net u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data), .start(start),
    .chk_unsat(chk_unsat), .busy(busy), .done(done), .neut(neut)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // Fan configuration: {unsat[3:0], expected neut[7:0]}.
  localparam logic [11:0] FAN_VEC [0:7] = '{
    12'h0_00, 12'h1_01, 12'h2_10, 12'h4_80,
    12'h8_80, 12'hC_80, 12'hF_91, 12'h3_11
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] k, input logic [3:0] idx, input logic [3:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = k; cfg_idx = idx; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Returns at the negedge after the start edge.
  task automatic launch(input logic [3:0] u);
    @(negedge clk);
    start = 1'b1; chk_unsat = u;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic full_run(input logic [3:0] u);
    launch(u);
    repeat (NT) @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_kind = 2'd0; cfg_idx = 4'd0;
    cfg_data = 4'd0; start = 1'b0; chk_unsat = 4'd0;
    do_reset();

    // R1: reset state and empty configuration.
    check("R1 busy", {7'd0, busy}, 8'h00);
    check("R1 done", {7'd0, done}, 8'h00);
    check("R1 neut", neut, 8'h00);
    full_run(4'hF);
    check("R1 no seed after reset", neut, 8'h00);
    check("R5 done after empty run", {7'd0, done}, 8'h01);

    // Fan table: seeds on edges 0, 6, 11, 13 (R8 kind 1, R9 map).
    wr(2'd1, 4'd0, 4'h1);
    wr(2'd1, 4'd6, 4'h1);
    wr(2'd1, 4'd11, 4'h1);
    wr(2'd1, 4'd13, 4'h1);
    for (int i = 0; i < 8; i++) begin
      full_run(FAN_VEC[i][11:8]);
      check("R2 R7 R9 fan", neut, FAN_VEC[i][7:0]);
    end

    // R1: reset wipes stored configuration.
    do_reset();
    full_run(4'hF);
    check("R1 config cleared", neut, 8'h00);

    // Chain v0 -> c3 -> v1 -> c0 -> v2 -> c1 -> (v3 dropped).
    wr(2'd1, 4'd0, 4'h1);
    wr(2'd0, 4'd0, 4'h1);
    wr(2'd0, 4'd1, 4'h1);
    wr(2'd0, 4'd2, 4'h1);
    wr(2'd2, 4'd15, 4'h4);
    wr(2'd2, 4'd2, 4'h2);
    wr(2'd2, 4'd5, 4'h1);
    launch(4'h1);
    check("R6 cleared at start", neut, 8'h00);
    @(negedge clk);
    check("R2 seed lands after one edge", neut, 8'h01);
    check("R5 busy during run", {7'd0, busy}, 8'h01);
    @(negedge clk);
    check("R5 one hop per cycle", neut, 8'h01);
    @(negedge clk);
    check("R4 mask relays to v1", neut, 8'h03);
    repeat (2) @(negedge clk);
    check("R5 in-flight token dropped", neut, 8'h07);
    check("R5 done pulse", {6'd0, busy, done}, 8'h01);
    @(negedge clk);
    check("R5 done lasts one cycle", {7'd0, done}, 8'h00);
    check("R6 flags held after run", neut, 8'h07);
    full_run(4'h0);
    check("R6 cleared by next start", neut, 8'h00);

    // R4: mask bit for the wrong link blocks the relay.
    wr(2'd2, 4'd15, 4'h2);
    full_run(4'h1);
    check("R4 wrong mask bit", neut, 8'h01);

    // R3: no echo back to the sending check.
    do_reset();
    wr(2'd1, 4'd0, 4'h1);
    wr(2'd0, 4'd0, 4'h1);
    wr(2'd2, 4'd1, 4'h1);
    full_run(4'h1);
    check("R3 no return to sender", neut, 8'h01);
    wr(2'd0, 4'd0, 4'h0);
    wr(2'd2, 4'd15, 4'h4);
    full_run(4'h1);
    check("R3 relay bit clear", neut, 8'h01);
    // R8: variable index beyond range is ignored.
    wr(2'd0, 4'd8, 4'h1);
    full_run(4'h1);
    check("R8 out-of-range write", neut, 8'h01);
    wr(2'd0, 4'd0, 4'h1);
    full_run(4'h1);
    check("R3 relay bit set", neut, 8'h03);

    summary();
  end
endmodule